// File: doc/BRIEF.md
# Streaming Sobel Edge Magnitude Filter

This block sits in a raster video path and turns a stream of grayscale pixels into a stream of edge strengths. Pixels arrive one per accepted strobe. A start-of-frame flag marks the first pixel of a picture, and an end-of-line flag marks the last pixel of each row. Two row stores hold the two previous lines. Each new pixel therefore completes a 3x3 neighbourhood in a bank of window registers, and no pixel is read from memory a second time.

Both gradient directions are evaluated on the same neighbourhood. They are summed as absolute values and clipped to the pixel range. The arithmetic runs digit-serially, DIGIT_W bits of every tap per clock, so one pixel takes PIX_W/DIGIT_W clocks; with the defaults that is four clocks per pixel. The block paces its input with a ready signal. Each accepted pixel produces exactly one output pixel, so the output stream has the same size as the input frame. The output value belongs to the window centre, one row up and one column left of the newest pixel.

Top module: `sobel_edge_stream`

## Requirements
- R1: While reset is held and after it is released, `out_valid` is 0 and `in_ready` is 1.
- R2: A pixel is taken on a rising edge where `in_valid` and `in_ready` are both 1. After that edge `in_ready` is 0 for three cycles and returns to 1 in the fourth, so at most one pixel enters every four clocks.
- R3: Each accepted pixel yields exactly one single-cycle `out_valid` pulse. The pulse becomes visible after the fourth rising edge that follows the accepting edge.
- R4: Let the pixel that produces an output sit at row r, column c. The output carries the filtered value of the window centred on row r-1, column c-1 of the same frame.
- R5: The output is 0 when r < 2 or c < 2. This covers a window centre on the first row, the first column, or the last column of the line before.
- R6: The output value is |Gx|+|Gy|, clipped to 255. Gx is the right column of the window minus the left column, and Gy is the bottom row minus the top row. In both, the middle tap has weight 2 and the outer taps weight 1. A flat area gives 0.
- R7: A pixel with `in_sof` = 1 is taken as row 0, column 0, whatever the counters held before.
- R8: A pixel with `in_eol` = 1 ends its line, and the next pixel is column 0 of the next row. A line also ends by itself after LINE_W pixels. Shorter lines ended by `in_eol` are filtered at their own width.
- R9: While `in_ready` is 0, values on `in_valid`, `in_pix`, `in_sof` and `in_eol` have no effect on the output stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, four times the pixel rate with the defaults |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pixel present |
| in_sof | input | 1 | This pixel is the first of a frame |
| in_eol | input | 1 | This pixel is the last of its line |
| in_pix | input | PIX_W | Grayscale input pixel |
| in_ready | output | 1 | Block can take a pixel on this edge |
| out_valid | output | 1 | Output pixel present for one cycle |
| out_pix | output | PIX_W | Clipped edge magnitude |

## Verification
The filter is driven with several frame contents:
- A flat frame shows that the gradients cancel to zero.
- A ramp gives distinct unclipped values that expose wrong weights or wrong tap positions.
- A pseudo-random texture catches misalignment between the row stores and the window.
- A step and a checkerboard drive the magnitude into clipping.

The framing is tried in three ways: lines closed only by the width count, shorter lines closed by the end-of-line flag, and a frame abandoned part way through and restarted by start-of-frame. Two pacing patterns are used. One inserts idle gaps. The other holds misleading values on every input during the busy cycles, so any sampling outside the handshake would show up as wrong pixels or extra outputs.

// File: rtl/sobel_pkg.sv
package sobel_pkg;
   // Neighbourhood geometry
   localparam int unsigned WIN_SIDE = 3;
   localparam int unsigned WIN_TAPS = WIN_SIDE * WIN_SIDE;
   // Number of earlier rows kept in line storage
   localparam int unsigned HIST_ROWS = WIN_SIDE - 1;

   typedef enum logic {
      CORE_IDLE = 1'b0,
      CORE_BUSY = 1'b1
   } core_state_e;
endpackage

// File: rtl/sobel_line_store.sv
module sobel_line_store #(
   parameter int unsigned PIX_W = 8,
   parameter int unsigned DEPTH = 640,
   parameter int unsigned LINES = 2,
   localparam int unsigned AW = $clog2(DEPTH)
) (
   input  logic                        clk,
   input  logic                        wr_en,
   input  logic [AW-1:0]               addr,
   input  logic [PIX_W-1:0]            din,
   output logic [LINES-1:0][PIX_W-1:0] taps
);
   // Cascade of row memories: line k holds the row k+1 above the current one.
   for (genvar k = 0; k < LINES; k++) begin : g_line
      logic [PIX_W-1:0] mem [DEPTH];
      assign taps[k] = mem[addr];
      if (k == 0) begin : g_head
         always_ff @(posedge clk) begin
            if (wr_en) mem[addr] <= din;
         end
      end else begin : g_chain
         always_ff @(posedge clk) begin
            if (wr_en) mem[addr] <= taps[k-1];
         end
      end
   end
endmodule

// File: rtl/sobel_window3.sv
module sobel_window3
   import sobel_pkg::*;
#(
   parameter int unsigned PIX_W = 8
) (
   input  logic                           clk,
   input  logic                           rst,
   input  logic                           shift,
   input  logic [WIN_SIDE-1:0][PIX_W-1:0] new_col,  // index 0 = oldest row
   output logic [WIN_TAPS-1:0][PIX_W-1:0] win       // index = row*3 + col
);
   for (genvar r = 0; r < WIN_SIDE; r++) begin : g_row
      for (genvar c = 0; c < WIN_SIDE; c++) begin : g_col
         localparam int unsigned T = r * WIN_SIDE + c;
         always_ff @(posedge clk) begin
            if (rst) begin
               win[T] <= '0;
            end else if (shift) begin
               if (c == WIN_SIDE - 1) win[T] <= new_col[r];
               else                   win[T] <= win[T+1];
            end
         end
      end
   end
endmodule

// File: rtl/sobel_digit_core.sv
module sobel_digit_core
   import sobel_pkg::*;
#(
   parameter int unsigned PIX_W   = 8,
   parameter int unsigned DIGIT_W = 2,
   localparam int unsigned NDIG  = PIX_W / DIGIT_W,
   localparam int unsigned DG_W  = (NDIG > 1) ? $clog2(NDIG) : 1,
   localparam int unsigned PW_W  = DIGIT_W + 2,
   localparam int unsigned ACC_W = PIX_W + 4
) (
   input  logic                           clk,
   input  logic                           rst,
   input  logic                           start,
   input  logic                           interior,
   input  logic [WIN_TAPS-1:0][PIX_W-1:0] win,
   output logic                           ready,
   output logic                           out_valid,
   output logic [PIX_W-1:0]               out_pix
);
   core_state_e             state_q;
   logic [DG_W-1:0]         dg_q;
   logic                    mask_q;
   logic signed [ACC_W-1:0] acc_x_q, acc_y_q;

   logic last;
   assign last  = (dg_q == DG_W'(NDIG - 1));
   assign ready = (state_q == CORE_IDLE) || last;

   // Slice the current digit out of every tap
   logic [WIN_TAPS-1:0][DIGIT_W-1:0] dgt;
   for (genvar t = 0; t < WIN_TAPS; t++) begin : g_tap
      assign dgt[t] = win[t][dg_q*DIGIT_W +: DIGIT_W];
   end

   function automatic logic [PW_W-1:0] wsum(input logic [DIGIT_W-1:0] a,
                                            input logic [DIGIT_W-1:0] b,
                                            input logic [DIGIT_W-1:0] c);
      return PW_W'(a) + (PW_W'(b) << 1) + PW_W'(c);
   endfunction

   logic [PW_W-1:0]         gx_pos, gx_neg, gy_pos, gy_neg;
   logic signed [ACC_W-1:0] dx, dy, px, py, tot_x, tot_y;
   logic [ACC_W-1:0]        abs_x, abs_y;
   logic [ACC_W:0]          mag;
   logic [PIX_W-1:0]        mag_sat;

   always_comb begin
      gx_pos = wsum(dgt[2], dgt[5], dgt[8]);
      gx_neg = wsum(dgt[0], dgt[3], dgt[6]);
      gy_pos = wsum(dgt[6], dgt[7], dgt[8]);
      gy_neg = wsum(dgt[0], dgt[1], dgt[2]);
      dx     = $signed(ACC_W'(gx_pos)) - $signed(ACC_W'(gx_neg));
      dy     = $signed(ACC_W'(gy_pos)) - $signed(ACC_W'(gy_neg));
      px     = dx <<< (int'(dg_q) * DIGIT_W);
      py     = dy <<< (int'(dg_q) * DIGIT_W);
      tot_x  = acc_x_q + px;
      tot_y  = acc_y_q + py;
      abs_x  = tot_x[ACC_W-1] ? ACC_W'(-tot_x) : ACC_W'(tot_x);
      abs_y  = tot_y[ACC_W-1] ? ACC_W'(-tot_y) : ACC_W'(tot_y);
      mag    = (ACC_W+1)'(abs_x) + (ACC_W+1)'(abs_y);
      mag_sat = (mag > (ACC_W+1)'({PIX_W{1'b1}})) ? {PIX_W{1'b1}} : mag[PIX_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q   <= CORE_IDLE;
         dg_q      <= '0;
         mask_q    <= 1'b0;
         acc_x_q   <= '0;
         acc_y_q   <= '0;
         out_valid <= 1'b0;
         out_pix   <= '0;
      end else begin
         out_valid <= (state_q == CORE_BUSY) && last;
         if ((state_q == CORE_BUSY) && last) out_pix <= mask_q ? mag_sat : '0;
         if (start) begin
            state_q <= CORE_BUSY;
            dg_q    <= '0;
            mask_q  <= interior;
            acc_x_q <= '0;
            acc_y_q <= '0;
         end else if (state_q == CORE_BUSY) begin
            dg_q    <= dg_q + 1'b1;
            acc_x_q <= tot_x;
            acc_y_q <= tot_y;
            if (last) state_q <= CORE_IDLE;
         end
      end
   end
endmodule

// File: rtl/sobel_edge_stream.sv
module sobel_edge_stream
   import sobel_pkg::*;
#(
   parameter int unsigned PIX_W   = 8,
   parameter int unsigned LINE_W  = 640,
   parameter int unsigned DIGIT_W = 2,
   localparam int unsigned NDIG  = PIX_W / DIGIT_W,
   localparam int unsigned COL_W = $clog2(LINE_W)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic             in_sof,
   input  logic             in_eol,
   input  logic [PIX_W-1:0] in_pix,
   output logic             in_ready,
   output logic             out_valid,
   output logic [PIX_W-1:0] out_pix
);
   // Elaboration-time parameter checks
   if (PIX_W % DIGIT_W != 0) begin : g_bad_digit
      $error("PIX_W must be a multiple of DIGIT_W");
   end
   if (NDIG < 2) begin : g_bad_ndig
      $error("digit-serial core needs at least two digits per pixel");
   end
   if (LINE_W < 4) begin : g_bad_line
      $error("LINE_W must be at least 4");
   end

   logic accept;
   assign accept = in_valid && in_ready;

   // Raster position of the incoming pixel
   logic [COL_W-1:0] col_q, eff_col;
   logic [1:0]       row_q, eff_row;
   logic             line_end, interior;

   always_comb begin
      eff_col  = in_sof ? '0 : col_q;
      eff_row  = in_sof ? '0 : row_q;
      line_end = in_eol || (eff_col == COL_W'(LINE_W - 1));
      interior = (eff_row == 2'd2) && (eff_col >= COL_W'(2));
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         col_q <= '0;
         row_q <= '0;
      end else if (accept) begin
         col_q <= line_end ? '0 : eff_col + 1'b1;
         if (line_end && eff_row != 2'd2) row_q <= eff_row + 1'b1;
         else                             row_q <= eff_row;
      end
   end

   logic [HIST_ROWS-1:0][PIX_W-1:0] hist;

   sobel_line_store #(
      .PIX_W (PIX_W),
      .DEPTH (LINE_W),
      .LINES (HIST_ROWS)
   ) lines_i (
      .clk   (clk),
      .wr_en (accept),
      .addr  (eff_col),
      .din   (in_pix),
      .taps  (hist)
   );

   logic [WIN_SIDE-1:0][PIX_W-1:0] new_col;
   logic [WIN_TAPS-1:0][PIX_W-1:0] win;
   assign new_col = {in_pix, hist[0], hist[1]};

   sobel_window3 #(.PIX_W(PIX_W)) win_i (
      .clk     (clk),
      .rst     (rst),
      .shift   (accept),
      .new_col (new_col),
      .win     (win)
   );

   sobel_digit_core #(.PIX_W(PIX_W), .DIGIT_W(DIGIT_W)) core_i (
      .clk       (clk),
      .rst       (rst),
      .start     (accept),
      .interior  (interior),
      .win       (win),
      .ready     (in_ready),
      .out_valid (out_valid),
      .out_pix   (out_pix)
   );
endmodule

// File: rtl/sobel_edge_stream_chk.sv
module sobel_edge_stream_chk #(
   parameter int unsigned NDIG = 4
) (
   input logic clk,
   input logic rst,
   input logic in_valid,
   input logic in_ready,
   input logic out_valid
);
   logic [7:0] lat_q;
   always_ff @(posedge clk) begin
      if (rst)                      lat_q <= '0;
      else if (in_valid && in_ready) lat_q <= 8'd1;
      else if (lat_q != 8'd0 && lat_q != 8'hFF) lat_q <= lat_q + 8'd1;
   end

   // R1
   reset_idle_chk: assert property (@(posedge clk) rst |=> (!out_valid && in_ready));

   // R2
   ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready) |=> !in_ready);

   // R3
   single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid |=> !out_valid);

   // R3
   out_latency_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> ($past(lat_q) == 8'(NDIG)));

   // R2
   out_after_ready_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> $past(in_ready));
endmodule

bind sobel_edge_stream sobel_edge_stream_chk #(.NDIG(NDIG)) chk_i (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .out_valid (out_valid)
);

// File: tb/sobel_edge_stream_tb_top.sv
module sobel_edge_stream_tb_top;
   localparam int LW = 8;
   localparam int FH = 6;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic in_valid = 1'b0, in_sof = 1'b0, in_eol = 1'b0;
   logic [7:0] in_pix = '0;
   logic in_ready, out_valid;
   logic [7:0] out_pix;

   always #4 clk = ~clk;

   sobel_edge_stream #(.PIX_W(8), .LINE_W(LW), .DIGIT_W(2)) dut_i (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_eol(in_eol),
      .in_pix(in_pix), .in_ready(in_ready), .out_valid(out_valid), .out_pix(out_pix)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 0;
   string cur_tag = "R4";
   int exp_q[$];
   int fr [FH][LW];

   task automatic chk(input string tag, input int act, input int expv);
      checks++;
      if (act != expv) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   // Output collector
   always @(negedge clk) begin
      if (!rst && out_valid) begin
         if (exp_q.size() == 0) begin
            chk({cur_tag, "/R3 unexpected output"}, 1, 0);
         end else begin
            chk(cur_tag, int'(out_pix), exp_q.pop_front());
         end
      end
   end

   function automatic int pat_pix(input int pat, input int r, input int c);
      case (pat)
         0: return 100;
         1: return c * 7 + r * 3;
         2: return (r * 37 + c * 91 + r * c * 13 + 5) & 255;
         3: return (c < 4) ? 10 : 200;
         default: return ((r + c) % 2 == 1) ? 255 : 0;
      endcase
   endfunction

   // Expected output for the pixel at (r,c): R4, R5, R6
   function automatic int exp_at(input int r, input int c);
      int cr, cc, gx, gy, m;
      if (r < 2 || c < 2) return 0;
      cr = r - 1; cc = c - 1;
      gx = fr[cr-1][cc+1] + 2*fr[cr][cc+1] + fr[cr+1][cc+1]
         - fr[cr-1][cc-1] - 2*fr[cr][cc-1] - fr[cr+1][cc-1];
      gy = fr[cr+1][cc-1] + 2*fr[cr+1][cc] + fr[cr+1][cc+1]
         - fr[cr-1][cc-1] - 2*fr[cr-1][cc] - fr[cr-1][cc+1];
      m = (gx < 0 ? -gx : gx) + (gy < 0 ? -gy : gy);
      return (m > 255) ? 255 : m;
   endfunction

   task automatic put_pix(input int p, input bit s, input bit e, input bit garbage, input int gap);
      @(negedge clk);
      repeat (gap) begin
         in_valid = 1'b0;
         @(negedge clk);
      end
      while (!in_ready) begin
         in_valid = garbage; in_pix = 8'h5A; in_sof = garbage; in_eol = garbage;
         @(negedge clk);
      end
      in_valid = 1'b1; in_pix = 8'(p); in_sof = s; in_eol = e;
      @(posedge clk);
   endtask

   task automatic drain();
      @(negedge clk);
      in_valid = 1'b0; in_sof = 1'b0; in_eol = 1'b0;
      repeat (12) @(negedge clk);
      chk({cur_tag, "/R3 pending outputs"}, exp_q.size(), 0);
   endtask

   task automatic send_frame(input string tag, input int pat, input int len, input int rows,
                             input bit use_eol, input bit garbage, input int gap);
      cur_tag = tag;
      for (int r = 0; r < rows; r++)
         for (int c = 0; c < len; c++) fr[r][c] = pat_pix(pat, r, c);
      for (int r = 0; r < rows; r++) begin
         for (int c = 0; c < len; c++) begin
            exp_q.push_back(exp_at(r, c));
            put_pix(fr[r][c], (r == 0 && c == 0), use_eol && (c == len - 1), garbage, gap);
         end
      end
      drain();
   endtask

   task automatic t_reset();
      rst = 1'b1;
      in_valid = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1 out_valid in reset", int'(out_valid), 0);
      chk("R1 in_ready in reset", int'(in_ready), 1);
      rst = 1'b0;
      @(negedge clk);
      chk("R1 out_valid after reset", int'(out_valid), 0);
      chk("R1 in_ready after reset", int'(in_ready), 1);
   endtask

   task automatic t_handshake();
      cur_tag = "R3 single";
      exp_q.push_back(0);
      @(negedge clk);
      in_valid = 1'b1; in_pix = 8'd77; in_sof = 1'b1; in_eol = 1'b0;
      @(negedge clk);
      in_valid = 1'b0; in_sof = 1'b0;
      for (int i = 0; i < 3; i++) begin
         chk("R2 ready low after accept", int'(in_ready), 0);
         chk("R3 no early output", int'(out_valid), 0);
         @(negedge clk);
      end
      chk("R2 ready back", int'(in_ready), 1);
      chk("R3 no early output", int'(out_valid), 0);
      @(negedge clk);
      chk("R3 output pulse", int'(out_valid), 1);
      @(negedge clk);
      chk("R3 pulse single", int'(out_valid), 0);
   endtask

   task automatic t_restart();
      // R7: abandon a frame after 13 pixels, then start again with in_sof
      cur_tag = "R7 partial";
      for (int k = 0; k < 13; k++) begin
         exp_q.push_back(0);
         put_pix(200 - k * 9, (k == 0), ((k % LW) == LW - 1), 1'b0, 0);
      end
      send_frame("R7 restart", 2, LW, FH, 1'b1, 1'b0, 0);
   endtask

   initial begin
      t_reset();
      t_handshake();
      send_frame("R6 flat", 0, LW, FH, 1'b1, 1'b0, 0);
      send_frame("R4 ramp", 1, LW, FH, 1'b1, 1'b0, 0);
      send_frame("R4 texture", 2, LW, FH, 1'b1, 1'b0, 2);
      send_frame("R6 step saturate", 3, LW, FH, 1'b1, 1'b0, 0);
      send_frame("R6 checker saturate", 4, LW, FH, 1'b1, 1'b0, 1);
      send_frame("R9 busy inputs ignored", 2, LW, FH, 1'b1, 1'b1, 0);
      send_frame("R8 width wrap", 1, LW, FH, 1'b0, 1'b0, 0);
      send_frame("R8 short lines", 2, LW - 2, FH, 1'b1, 1'b0, 0);
      send_frame("R5 border", 4, LW, 3, 1'b1, 1'b0, 0);
      t_restart();
      t_reset();
      send_frame("R1 after second reset", 1, LW, FH, 1'b1, 1'b1, 0);
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule